// File: doc/BRIEF.md
# Instruction Line Fetch Requester

This block sits between the per-thread program counters of a multithreaded front end and an instruction memory. Each cycle it examines the threads that want instructions, aligns each wanted address to the start of a 64-byte line, and either reports a hit in that thread's private line buffer or sends a whole-line read request to memory. The request carries the thread number and a sequence tag, so a late response can be recognised and discarded.

Memory may refuse a request. The refused request is then parked in one slot that all threads share, and a global blocked flag stops every further request until memory signals a retry. Responses come back tagged with a thread number and a sequence tag. A response is kept only if that thread is still waiting and the tag matches the request the thread has outstanding. Any other response is dropped and counted. A squash of a thread forgets its outstanding request and releases the shared slot if the slot holds that thread's request.

Top module: `line_fetch_requester`

## Requirements
- R1: Every request address has its low log2(LINE_BYTES) bits (6 with defaults) cleared, whatever the offset of the fetch address.
- R2: A thread neither hits nor issues while the unit is blocked, while `switched_out` is high, while its `stall` bit is high, or while `intr_pend` is high and its `fetch_priv` bit is low.
- R3: A thread in RUN whose line buffer is valid and whose stored tag equals the aligned address raises its `fetch_hit` bit in the same cycle and makes no memory request.
- R4: A new request goes to the lowest-numbered eligible thread. Its `req_seq` equals a counter that starts at 0 and increments on each new request. The thread's tag is recorded and its line valid bit is cleared. If the request is accepted, the state becomes WAIT_RSP (code 1).
- R5: A refused new request is parked in the shared slot. `blocked` goes to 1 and the thread state becomes WAIT_RETRY (code 2).
- R6: A `retry_pulse` with a parked request resends it with the same address, thread and tag. If accepted, the thread goes to WAIT_RSP and `blocked` clears. If refused, the request stays parked. With no parked request, a retry issues nothing and leaves `blocked` at 0.
- R7: A response is dropped, and `sq_count` incremented, when its thread is not in WAIT_RSP, when its tag differs from the thread's outstanding tag, or when `switched_out` is high.
- R8: A kept response writes the line data and sets line valid. The thread goes to DONE (code 4), or to BLOCKED (code 3) if its stall bit is high in that cycle.
- R9: A squash returns the thread to RUN (code 0) and forgets its outstanding request, so that request's response is later dropped. If the parked request belongs to the thread, the slot is freed and `blocked` clears.
- R10: DONE returns to RUN after one cycle. RUN with stall high goes to BLOCKED. BLOCKED returns to RUN once stall is low.
- R11: After reset every thread is in RUN with no valid line, `blocked` is 0, `sq_count` is 0 and the sequence counter is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | NUM_THR | Thread wants instructions |
| fetch_addr | input | NUM_THR*ADDR_W | Per-thread fetch address |
| fetch_priv | input | NUM_THR | Thread runs in privileged physical mode |
| stall | input | NUM_THR | Downstream stall per thread |
| squash | input | NUM_THR | Squash per thread |
| intr_pend | input | 1 | Interrupt pending |
| switched_out | input | 1 | Unit is switched out |
| req_valid | output | 1 | Line read request |
| req_addr | output | ADDR_W | Line-aligned request address |
| req_tid | output | TID_W | Requesting thread |
| req_seq | output | SEQ_W | Request sequence tag |
| req_accept | input | 1 | Memory accepts the request this cycle |
| retry_pulse | input | 1 | Memory can take a refused request now |
| rsp_valid | input | 1 | Response present |
| rsp_tid | input | TID_W | Response thread |
| rsp_seq | input | SEQ_W | Response sequence tag |
| rsp_data | input | LINE_BYTES*8 | Line contents |
| fetch_hit | output | NUM_THR | Line buffer hit this cycle |
| thr_state | output | NUM_THR*3 | Per-thread state code |
| line_valid | output | NUM_THR | Line buffer valid |
| line_data | output | NUM_THR*LINE_BYTES*8 | Per-thread line buffer |
| blocked | output | 1 | Shared blocked flag |
| sq_count | output | CNT_W | Dropped-response counter |

## Verification
A wrong thread state shows up at the ports within one cycle. A stuck WAIT_RSP turns good responses into dropped ones and `sq_count` rises. A stuck BLOCKED or DONE stops the next `req_valid` or `fetch_hit` from appearing. A wrong slot or sequence tag appears on the resend cycle as a `req_tid`/`req_seq` mismatch. A `blocked` flag that does not clear suppresses every following request, which the directed sequence after the retry and squash cases exposes at once.

// File: rtl/lfr_pkg.sv
package lfr_pkg;
   typedef enum logic [2:0] {
      TS_RUN      = 3'd0,
      TS_WAIT_RSP = 3'd1,
      TS_WAIT_RTY = 3'd2,
      TS_BLOCKED  = 3'd3,
      TS_DONE     = 3'd4
   } thr_state_e;
endpackage

// File: rtl/lfr_prio_arb.sv
module lfr_prio_arb #(
   parameter int N   = 2,
   parameter int IDX = 1
) (
   input  logic [N-1:0]   want,
   output logic [N-1:0]   grant,
   output logic [IDX-1:0] gidx,
   output logic           any
);
   always_comb begin
      grant = '0;
      gidx  = '0;
      any   = 1'b0;
      for (int i = 0; i < N; i++) begin
         if (want[i] && !any) begin
            grant[i] = 1'b1;
            gidx     = IDX'(i);
            any      = 1'b1;
         end
      end
   end
endmodule

// File: rtl/lfr_retry_slot.sv
module lfr_retry_slot #(
   parameter int ADDR_W = 32,
   parameter int TID_W  = 1,
   parameter int SEQ_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              park,
   input  logic [TID_W-1:0]  park_tid,
   input  logic [ADDR_W-1:0] park_addr,
   input  logic [SEQ_W-1:0]  park_seq,
   input  logic              free,
   input  logic              retry_pulse,
   output logic              slot_valid,
   output logic [TID_W-1:0]  slot_tid,
   output logic [ADDR_W-1:0] slot_addr,
   output logic [SEQ_W-1:0]  slot_seq,
   output logic              blocked
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         slot_valid <= 1'b0;
         slot_tid   <= '0;
         slot_addr  <= '0;
         slot_seq   <= '0;
         blocked    <= 1'b0;
      end else if (park) begin
         slot_valid <= 1'b1;
         slot_tid   <= park_tid;
         slot_addr  <= park_addr;
         slot_seq   <= park_seq;
         blocked    <= 1'b1;
      end else if (free) begin
         slot_valid <= 1'b0;
         blocked    <= 1'b0;
      end else if (retry_pulse && !slot_valid) begin
         blocked    <= 1'b0;
      end
   end
endmodule

// File: rtl/lfr_thread_ctx.sv
module lfr_thread_ctx
   import lfr_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int SEQ_W  = 4,
   parameter int DATA_W = 512
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              issue,
   input  logic              issue_acc,
   input  logic [ADDR_W-1:0] issue_addr,
   input  logic [SEQ_W-1:0]  issue_seq,
   input  logic              resend_acc,
   input  logic              squash,
   input  logic              stall,
   input  logic              rsp_take,
   input  logic [DATA_W-1:0] rsp_data,
   output thr_state_e        state,
   output logic              lvalid,
   output logic [ADDR_W-1:0] ltag,
   output logic [DATA_W-1:0] ldata,
   output logic [SEQ_W-1:0]  pend_seq,
   output logic              pend_live
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= TS_RUN;
         lvalid    <= 1'b0;
         ltag      <= '0;
         ldata     <= '0;
         pend_seq  <= '0;
         pend_live <= 1'b0;
      end else if (squash) begin
         state     <= TS_RUN;
         pend_live <= 1'b0;
      end else if (issue) begin
         ltag      <= issue_addr;
         lvalid    <= 1'b0;
         pend_seq  <= issue_seq;
         pend_live <= 1'b1;
         state     <= issue_acc ? TS_WAIT_RSP : TS_WAIT_RTY;
      end else if (resend_acc) begin
         state     <= TS_WAIT_RSP;
      end else if (rsp_take) begin
         ldata     <= rsp_data;
         lvalid    <= 1'b1;
         pend_live <= 1'b0;
         state     <= stall ? TS_BLOCKED : TS_DONE;
      end else begin
         unique case (state)
            TS_RUN:     if (stall) state <= TS_BLOCKED;
            TS_BLOCKED: if (!stall) state <= TS_RUN;
            TS_DONE:    state <= TS_RUN;
            default:    state <= state;
         endcase
      end
   end
endmodule

// File: rtl/line_fetch_requester.sv
module line_fetch_requester
   import lfr_pkg::*;
#(
   parameter int NUM_THR    = 2,
   parameter int ADDR_W     = 32,
   parameter int LINE_BYTES = 64,
   parameter int SEQ_W      = 4,
   parameter int CNT_W      = 16,
   parameter int TID_W      = (NUM_THR > 1) ? $clog2(NUM_THR) : 1,
   parameter int DATA_W     = LINE_BYTES * 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_THR-1:0]        fetch_valid,
   input  logic [NUM_THR*ADDR_W-1:0] fetch_addr,
   input  logic [NUM_THR-1:0]        fetch_priv,
   input  logic [NUM_THR-1:0]        stall,
   input  logic [NUM_THR-1:0]        squash,
   input  logic                      intr_pend,
   input  logic                      switched_out,
   output logic                      req_valid,
   output logic [ADDR_W-1:0]         req_addr,
   output logic [TID_W-1:0]          req_tid,
   output logic [SEQ_W-1:0]          req_seq,
   input  logic                      req_accept,
   input  logic                      retry_pulse,
   input  logic                      rsp_valid,
   input  logic [TID_W-1:0]          rsp_tid,
   input  logic [SEQ_W-1:0]          rsp_seq,
   input  logic [DATA_W-1:0]         rsp_data,
   output logic [NUM_THR-1:0]        fetch_hit,
   output logic [NUM_THR*3-1:0]      thr_state,
   output logic [NUM_THR-1:0]        line_valid,
   output logic [NUM_THR*DATA_W-1:0] line_data,
   output logic                      blocked,
   output logic [CNT_W-1:0]          sq_count
);
   localparam int OFF_W = $clog2(LINE_BYTES);
   localparam logic [ADDR_W-1:0] OFF_MASK = ADDR_W'((1 << OFF_W) - 1);

   if ((1 << OFF_W) != LINE_BYTES) begin : g_bad_line
      $error("LINE_BYTES must be a power of two");
   end
   if (NUM_THR < 1 || (1 << TID_W) < NUM_THR) begin : g_bad_thr
      $error("NUM_THR does not fit TID_W");
   end
   if (SEQ_W < 2) begin : g_bad_seq
      $error("SEQ_W must be at least 2");
   end

   thr_state_e              st     [NUM_THR];
   logic [ADDR_W-1:0]       ltag   [NUM_THR];
   logic [ADDR_W-1:0]       alg    [NUM_THR];
   logic [SEQ_W-1:0]        pseq   [NUM_THR];
   logic [NUM_THR-1:0]      plive, lv, want, grant, issue_t, resend_acc_t, take_t;
   logic [TID_W-1:0]        gidx;
   logic                    any_want, resend, new_issue, park, slot_free;
   logic                    slot_valid;
   logic [TID_W-1:0]        slot_tid;
   logic [ADDR_W-1:0]       slot_addr;
   logic [SEQ_W-1:0]        slot_seq;
   logic [SEQ_W-1:0]        seq_ctr;
   logic                    slot_thr_squashed;

   // per-thread eligibility, hit detection and context
   for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
      logic gate_ok;
      assign alg[t]   = fetch_addr[t*ADDR_W +: ADDR_W] & ~OFF_MASK;
      assign gate_ok  = fetch_valid[t] && (st[t] == TS_RUN) && !blocked &&
                        !switched_out && !stall[t] && !squash[t] &&
                        !(intr_pend && !fetch_priv[t]);
      assign fetch_hit[t] = gate_ok && lv[t] && (ltag[t] == alg[t]);
      assign want[t]      = gate_ok && !fetch_hit[t];
      assign issue_t[t]   = new_issue && grant[t];
      assign resend_acc_t[t] = resend && req_accept && (slot_tid == TID_W'(t));
      assign take_t[t]    = rsp_valid && (rsp_tid == TID_W'(t)) &&
                            (st[t] == TS_WAIT_RSP) && plive[t] &&
                            (pseq[t] == rsp_seq) && !switched_out && !squash[t];
      assign thr_state[t*3 +: 3] = st[t];
      assign line_valid[t] = lv[t];

      lfr_thread_ctx #(
         .ADDR_W (ADDR_W),
         .SEQ_W  (SEQ_W),
         .DATA_W (DATA_W)
      ) u_ctx (
         .clk        (clk),
         .rst_n      (rst_n),
         .issue      (issue_t[t]),
         .issue_acc  (req_accept),
         .issue_addr (alg[t]),
         .issue_seq  (seq_ctr),
         .resend_acc (resend_acc_t[t]),
         .squash     (squash[t]),
         .stall      (stall[t]),
         .rsp_take   (take_t[t]),
         .rsp_data   (rsp_data),
         .state      (st[t]),
         .lvalid     (lv[t]),
         .ltag       (ltag[t]),
         .ldata      (line_data[t*DATA_W +: DATA_W]),
         .pend_seq   (pseq[t]),
         .pend_live  (plive[t])
      );
   end

   lfr_prio_arb #(
      .N   (NUM_THR),
      .IDX (TID_W)
   ) u_arb (
      .want  (want),
      .grant (grant),
      .gidx  (gidx),
      .any   (any_want)
   );

   always_comb begin
      slot_thr_squashed = 1'b0;
      for (int i = 0; i < NUM_THR; i++)
         if (squash[i] && slot_tid == TID_W'(i)) slot_thr_squashed = 1'b1;
   end

   assign resend    = retry_pulse && slot_valid && !slot_thr_squashed;
   assign new_issue = any_want && !resend;
   assign park      = new_issue && !req_accept;
   assign slot_free = (resend && req_accept) || (slot_valid && slot_thr_squashed);

   assign req_valid = resend || new_issue;
   assign req_addr  = resend ? slot_addr : alg[gidx];
   assign req_tid   = resend ? slot_tid  : gidx;
   assign req_seq   = resend ? slot_seq  : seq_ctr;

   lfr_retry_slot #(
      .ADDR_W (ADDR_W),
      .TID_W  (TID_W),
      .SEQ_W  (SEQ_W)
   ) u_slot (
      .clk         (clk),
      .rst_n       (rst_n),
      .park        (park),
      .park_tid    (gidx),
      .park_addr   (alg[gidx]),
      .park_seq    (seq_ctr),
      .free        (slot_free),
      .retry_pulse (retry_pulse),
      .slot_valid  (slot_valid),
      .slot_tid    (slot_tid),
      .slot_addr   (slot_addr),
      .slot_seq    (slot_seq),
      .blocked     (blocked)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         seq_ctr  <= '0;
         sq_count <= '0;
      end else begin
         if (new_issue) seq_ctr <= seq_ctr + 1'b1;
         if (rsp_valid && !(|take_t)) sq_count <= sq_count + 1'b1;
      end
   end
endmodule

// File: rtl/line_fetch_requester_chk.sv
module line_fetch_requester_chk #(
   parameter int NUM_THR    = 2,
   parameter int ADDR_W     = 32,
   parameter int LINE_BYTES = 64,
   parameter int CNT_W      = 16,
   parameter int TID_W      = 1
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 req_valid,
   input logic [ADDR_W-1:0]    req_addr,
   input logic                 req_accept,
   input logic                 retry_pulse,
   input logic                 blocked,
   input logic                 rsp_valid,
   input logic [TID_W-1:0]     rsp_tid,
   input logic                 switched_out,
   input logic [NUM_THR*3-1:0] thr_state,
   input logic [NUM_THR-1:0]   line_valid,
   input logic [CNT_W-1:0]     sq_count
);
   localparam int OFF_W = $clog2(LINE_BYTES);
   logic [2:0] rsp_st;

   always_comb begin
      rsp_st = 3'd7;
      for (int i = 0; i < NUM_THR; i++)
         if (rsp_tid == TID_W'(i)) rsp_st = thr_state[i*3 +: 3];
   end

   assert_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> (req_addr[OFF_W-1:0] == '0));

   assert_quiet_when_blocked_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (blocked && !retry_pulse) |-> !req_valid);

   assert_park_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_accept) |=> blocked);

   assert_retry_unblocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (retry_pulse && blocked && req_valid && req_accept) |=> !blocked);

   assert_drop_counted_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && (rsp_st != 3'd1 || switched_out)) |=>
      (sq_count == $past(sq_count) + CNT_W'(1)));

   for (genvar t = 0; t < NUM_THR; t++) begin : g_t
      assert_valid_from_rsp_R8: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(line_valid[t]) |-> $past(rsp_valid));
      assert_legal_state_R10: assert property (@(posedge clk) disable iff (!rst_n)
         thr_state[t*3 +: 3] <= 3'd4);
   end
endmodule

bind line_fetch_requester line_fetch_requester_chk #(
   .NUM_THR    (NUM_THR),
   .ADDR_W     (ADDR_W),
   .LINE_BYTES (LINE_BYTES),
   .CNT_W      (CNT_W),
   .TID_W      (TID_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_valid    (req_valid),
   .req_addr     (req_addr),
   .req_accept   (req_accept),
   .retry_pulse  (retry_pulse),
   .blocked      (blocked),
   .rsp_valid    (rsp_valid),
   .rsp_tid      (rsp_tid),
   .switched_out (switched_out),
   .thr_state    (thr_state),
   .line_valid   (line_valid),
   .sq_count     (sq_count)
);

// File: tb/sim_line_fetch_requester.sv
`timescale 1ns/1ps
module sim_line_fetch_requester;
   localparam int NT = 2, AW = 32, LB = 64, SW = 4, CW = 16, TW = 1, DW = LB*8;

   logic clk = 1'b0, rst_n = 1'b0;
   logic [NT-1:0] fv = '0, fpriv = '0, stl = '0, sq = '0;
   logic [NT*AW-1:0] fa = '0;
   logic intr = 1'b0, swo = 1'b0, acc = 1'b0, rty = 1'b0, rv = 1'b0;
   logic [TW-1:0] rtid = '0;
   logic [SW-1:0] rseq = '0;
   logic [DW-1:0] rdata = '0;
   logic req_valid, blocked;
   logic [AW-1:0] req_addr;
   logic [TW-1:0] req_tid;
   logic [SW-1:0] req_seq;
   logic [NT-1:0] hit, lval;
   logic [NT*3-1:0] tst;
   logic [NT*DW-1:0] ldata;
   logic [CW-1:0] sqc;

   int checks = 0, errors = 0;
   bit done = 0;
   int seq = 0;
   int cnt = 0;

   always #5 clk = ~clk;

   line_fetch_requester #(.NUM_THR(NT), .ADDR_W(AW), .LINE_BYTES(LB),
      .SEQ_W(SW), .CNT_W(CW)) u0 (
      .clk(clk), .rst_n(rst_n), .fetch_valid(fv), .fetch_addr(fa),
      .fetch_priv(fpriv), .stall(stl), .squash(sq), .intr_pend(intr),
      .switched_out(swo), .req_valid(req_valid), .req_addr(req_addr),
      .req_tid(req_tid), .req_seq(req_seq), .req_accept(acc),
      .retry_pulse(rty), .rsp_valid(rv), .rsp_tid(rtid), .rsp_seq(rseq),
      .rsp_data(rdata), .fetch_hit(hit), .thr_state(tst), .line_valid(lval),
      .line_data(ldata), .blocked(blocked), .sq_count(sqc));

   task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   function automatic logic [DW-1:0] pat(input logic [31:0] k);
      return {16{k ^ 32'hA5C3_0F17}};
   endfunction

   function automatic logic [2:0] sget(input int t);
      return tst[t*3 +: 3];
   endfunction

   // start a fetch on thread t; returns after the issue edge
   task automatic issue(input int t, input logic [31:0] a, input logic take, input string rq);
      fv[t] = 1'b1; fa[t*AW +: AW] = a; acc = take;
      #1;
      chk({rq, " req_valid"}, 64'(req_valid), 64'd1);
      chk({rq, " req_addr aligned"}, 64'(req_addr), 64'(a & ~32'h3F));
      chk({rq, " req_tid"}, 64'(req_tid), 64'(t));
      chk({rq, " req_seq"}, 64'(req_seq), 64'(seq % 16));
      tick();
      fv[t] = 1'b0; acc = 1'b0;
      seq++;
   endtask

   task automatic respond(input int t, input int s, input logic [DW-1:0] d);
      rv = 1'b1; rtid = TW'(t); rseq = SW'(s); rdata = d;
      tick();
      rv = 1'b0;
      #1;
   endtask

   localparam logic [31:0] TAB [6] = '{32'h0000_0000, 32'h0000_1234,
      32'h0000_103F, 32'hFFFF_FFC1, 32'h8000_0040, 32'h1234_5678};

   initial begin
      repeat (3) tick();
      // R11 reset state
      chk("R11 state0", 64'(sget(0)), 0);
      chk("R11 state1", 64'(sget(1)), 0);
      chk("R11 line_valid", 64'(lval), 0);
      chk("R11 sq_count", 64'(sqc), 0);
      chk("R11 blocked", 64'(blocked), 0);
      rst_n = 1'b1;
      tick();
      chk("R11 no request", 64'(req_valid), 0);

      // table walk: R1 R4 R8 R10
      for (int i = 0; i < 6; i++) begin
         issue(0, TAB[i], 1'b1, "R1 R4 table");
         chk("R4 wait state", 64'(sget(0)), 1);
         chk("R4 valid cleared", 64'(lval[0]), 0);
         respond(0, seq - 1, pat(TAB[i]));
         chk("R8 done state", 64'(sget(0)), 4);
         chk("R8 line valid", 64'(lval[0]), 1);
         chk("R8 line data", 64'(ldata[63:0]), 64'(pat(TAB[i])));
         tick();
         chk("R10 done to run", 64'(sget(0)), 0);
      end

      // R3 hit in same line, different offset
      fv[0] = 1'b1; fa[AW-1:0] = 32'h1234_5640;
      #1;
      chk("R3 hit", 64'(hit[0]), 1);
      chk("R3 no request", 64'(req_valid), 0);
      fv[0] = 1'b0;

      // R4 priority: both threads ask, thread 0 wins
      fv = 2'b11; fa = {32'h0000_2000, 32'h0000_3000}; acc = 1'b1;
      #1;
      chk("R4 priority tid", 64'(req_tid), 0);
      tick(); seq++;
      chk("R4 t1 still run", 64'(sget(1)), 0);
      issue(1, 32'h0000_2000, 1'b1, "R4 second");
      fv = '0;
      // R7 wrong tag on thread 0 is dropped
      cnt = int'(sqc);
      respond(0, seq - 2 + 1, pat(1));
      chk("R7 stale tag counted", 64'(sqc), 64'(cnt + 1));
      chk("R7 still waiting", 64'(sget(0)), 1);
      respond(0, seq - 2, pat(2));
      chk("R8 good after stale", 64'(sget(0)), 4);
      // R8 stall at response -> blocked, then R10 release
      stl[1] = 1'b1;
      respond(1, seq - 1, pat(3));
      chk("R8 blocked on stall", 64'(sget(1)), 3);
      stl[1] = 1'b0;
      tick();
      chk("R10 blocked to run", 64'(sget(1)), 0);
      // R7 response for idle thread
      cnt = int'(sqc);
      respond(1, 0, pat(4));
      chk("R7 idle drop", 64'(sqc), 64'(cnt + 1));

      // R5 refused -> parked; R2 blocked; R6 retry
      issue(1, 32'h0000_4444, 1'b0, "R5 refused");
      chk("R5 blocked", 64'(blocked), 1);
      chk("R5 wait retry", 64'(sget(1)), 2);
      fv[0] = 1'b1; fa[AW-1:0] = 32'h0000_9000;
      #1;
      chk("R2 blocked no req", 64'(req_valid), 0);
      fv[0] = 1'b0;
      rty = 1'b1; acc = 1'b0;
      #1;
      chk("R6 resend tid", 64'(req_tid), 1);
      chk("R6 resend seq", 64'(req_seq), 64'((seq - 1) % 16));
      chk("R6 resend addr", 64'(req_addr), 64'h4440);
      tick();
      chk("R6 refused stays blocked", 64'(blocked), 1);
      acc = 1'b1;
      tick();
      rty = 1'b0; acc = 1'b0;
      chk("R6 accepted state", 64'(sget(1)), 1);
      chk("R6 unblocked", 64'(blocked), 0);
      respond(1, seq - 1, pat(5));
      tick();
      rty = 1'b1;
      #1;
      chk("R6 empty retry no req", 64'(req_valid), 0);
      tick(); rty = 1'b0;
      chk("R6 empty retry unblocked", 64'(blocked), 0);

      // R9 squash frees parked slot of that thread
      issue(1, 32'h0000_5000, 1'b0, "R9 park");
      sq[1] = 1'b1;
      tick(); sq = '0;
      chk("R9 slot freed", 64'(blocked), 0);
      chk("R9 run", 64'(sget(1)), 0);
      // R9 squash forgets outstanding request
      issue(0, 32'h0000_6000, 1'b1, "R9 out");
      sq[0] = 1'b1;
      tick(); sq = '0;
      cnt = int'(sqc);
      respond(0, seq - 1, pat(6));
      chk("R9 late rsp dropped", 64'(sqc), 64'(cnt + 1));
      chk("R9 no line", 64'(lval[0]), 0);

      // R2 interrupt gating and privileged exemption
      intr = 1'b1; fv[0] = 1'b1; fa[AW-1:0] = 32'h0000_7000;
      #1;
      chk("R2 intr no req", 64'(req_valid), 0);
      fv[0] = 1'b0; fpriv[0] = 1'b1;
      issue(0, 32'h0000_7000, 1'b1, "R2 priv issues");
      intr = 1'b0; fpriv = '0;
      // R7 switched out drops a matching response
      swo = 1'b1;
      cnt = int'(sqc);
      respond(0, seq - 1, pat(7));
      chk("R7 switched out drop", 64'(sqc), 64'(cnt + 1));
      chk("R7 still waiting", 64'(sget(0)), 1);
      // R2 switched out blocks new requests
      fv[1] = 1'b1; fa[AW +: AW] = 32'h0000_8000;
      #1;
      chk("R2 switched out no req", 64'(req_valid), 0);
      fv[1] = 1'b0; swo = 1'b0;
      // R2 stall blocks request
      stl[1] = 1'b1; fv[1] = 1'b1;
      #1;
      chk("R2 stall no req", 64'(req_valid), 0);
      fv[1] = 1'b0; stl[1] = 1'b0;

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #2000000;
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule